// File: doc/BRIEF.md
# Reference Loss Detector

This block supervises a single reference clock input from a fast, free-running system clock and reports whether that reference is still alive. It only uses rising edges: each one restarts a gap counter, and when the counter reaches the nominal period plus a jitter allowance without a new edge, the reference is declared lost. The verdict goes to a reference selection controller as one flag, `ref_lost`.

Two reference classes are supported through a parameter: an 8 kHz frame reference and a 19.44 MHz line reference. The gap limit and the minimum lost-pulse length are computed in system-clock cycles from the class and the system clock rate. For the 8 kHz class the allowance is a quarter of the 125 µs period (31.25 µs) and the lost flag is held for at least 62.5 µs. For the 19.44 MHz class the allowance is 1 µs and the hold is at least 2 µs.

A four-state machine drives the flag:
- `ST_STARTUP` is entered on reset. The flag is high.
- `ST_PRESENT` means the reference is good. The flag is low.
- `ST_LOST_HOLD` is the minimum-width window. The flag is high and edges are ignored.
- `ST_LOST_WAIT` means the flag is still high and the machine is waiting for the next edge.

The transitions are:
- STARTUP→PRESENT on the first edge.
- PRESENT→LOST_HOLD when the gap limit is reached.
- LOST_HOLD→LOST_WAIT when the hold timer completes.
- LOST_WAIT→PRESENT on an edge.

Top module: `refmon_loss_det`

## Requirements
- R1: While reset is active and after it is released, `ref_lost` is 1 until the first rising edge of `ref_in`. A rise sampled by the negative-edge driver in cycle k clears `ref_lost` from cycle k+3 (two synchronizer flops plus the output register).
- R2: Rising edges spaced at most LIMIT system-clock cycles apart keep `ref_lost` at 0. LIMIT is the period plus the tolerance: 8 kHz class: ceil(KHZ/8) + ceil(KHZ/8)/4. 19.44 MHz class: ceil(KHZ/19440) + floor(KHZ/1000).
- R3: While the reference is present, a spacing of LIMIT+1 cycles or more sets `ref_lost`. With the last rise in cycle k and no further edge, `ref_lost` reads 1 from cycle k+LIMIT+4.
- R4: Once set by a timeout, `ref_lost` stays 1 for at least HOLD cycles, and rising edges during that window are ignored. HOLD is (ceil(KHZ/8)+1)/2 for the 8 kHz class and ceil(2·KHZ/1000) for the 19.44 MHz class.
- R5: After the hold window, the first rising edge clears `ref_lost`. `ref_lost` never falls without a preceding detected edge.
- R6: Only rising edges count. The width of the high phase and the timing of falling edges have no effect on the gap measurement.
- R7: A high pulse lasting one system-clock period is detected as one valid edge.
- R8: The class parameter selects the limits. With KHZ=800 the 8 kHz class gives LIMIT=125 and HOLD=50. With KHZ=20000 the 19.44 MHz class gives LIMIT=22 and HOLD=40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| ref_lost | output | 1 | 1 = reference absent or late, 0 = reference present |

## Verification
The assertions assume three things about the inputs:
- The system clock is fast enough that every high pulse of `ref_in` spans at least one full `clk` period.
- `ref_in` settles between clock edges.
- Reset is held long enough for the synchronizer to flush.

The stimulus keeps within these limits. Every reference pulse is at least one clock wide and is driven on the falling clock edge. Gaps are chosen at exactly LIMIT and at LIMIT+1, and the edges in the hold window land one cycle before and exactly at the first cycle where they may be accepted.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef enum logic {
        CLS_FRAME_8K = 1'b0,
        CLS_LINE_19M = 1'b1
    } ref_class_e;

    typedef enum logic [1:0] {
        ST_STARTUP   = 2'd0,
        ST_PRESENT   = 2'd1,
        ST_LOST_HOLD = 2'd2,
        ST_LOST_WAIT = 2'd3
    } mon_state_e;

    // Nominal reference period in system-clock cycles, rounded up
    function automatic int unsigned period_cycles(ref_class_e cls, int unsigned khz);
        if (cls == CLS_FRAME_8K) return (khz + 7) / 8;
        else                     return (khz + 19439) / 19440;
    endfunction

    // Allowed lateness in cycles, rounded down so the bound stays strict
    function automatic int unsigned tol_cycles(ref_class_e cls, int unsigned khz);
        if (cls == CLS_FRAME_8K) return period_cycles(cls, khz) / 4;
        else                     return khz / 1000;
    endfunction

    // Minimum lost-flag width in cycles, rounded up
    function automatic int unsigned hold_cycles(ref_class_e cls, int unsigned khz);
        if (cls == CLS_FRAME_8K) return (period_cycles(cls, khz) + 1) / 2;
        else                     return (2 * khz + 999) / 1000;
    endfunction

endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   last_q;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= ref_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= stage_q[SYNC_STAGES-1];
    end

    always_comb rise_pulse = stage_q[SYNC_STAGES-1] & ~last_q;

    // R7: one rising edge produces exactly one single-cycle pulse
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/refmon_gap_timer.sv
module refmon_gap_timer #(
    parameter int unsigned LIMIT_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT_CYC + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT_CYC);

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= '0;
        else if (restart)        gap_q <= '0;
        else if (gap_q != LIMIT_V) gap_q <= gap_q + 1'b1;
    end

    always_comb expired = (gap_q == LIMIT_V);

    // R2: an edge always gives a full fresh window
    p_restart_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired);

    // R3: the counter never runs past the limit
    p_gap_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= LIMIT_V);

endmodule

// File: rtl/refmon_hold_timer.sv
module refmon_hold_timer #(
    parameter int unsigned HOLD_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST_V = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hold_q <= '0;
        else if (run) hold_q <= hold_q + 1'b1;
        else          hold_q <= '0;
    end

    always_comb done = run && (hold_q == LAST_V);

    // R4: the controller leaves the hold window on completion, so done is one cycle
    p_done_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the count never exceeds the window while running
    p_hold_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> hold_q <= LAST_V);

endmodule

// File: rtl/refmon_loss_det.sv
module refmon_loss_det
    import refmon_pkg::*;
#(
    parameter int unsigned SYS_CLK_KHZ = 100000,
    parameter ref_class_e  REF_CLASS   = CLS_FRAME_8K,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_lost
);
    localparam int unsigned PERIOD_CYC = period_cycles(REF_CLASS, SYS_CLK_KHZ);
    localparam int unsigned TOL_CYC    = tol_cycles(REF_CLASS, SYS_CLK_KHZ);
    localparam int unsigned LIMIT_CYC  = PERIOD_CYC + TOL_CYC;
    localparam int unsigned HOLD_CYC   = hold_cycles(REF_CLASS, SYS_CLK_KHZ);
    localparam int unsigned LW         = $clog2(HOLD_CYC + 1);

    logic       rise;
    logic       gap_expired;
    logic       hold_done;
    mon_state_e state_q, state_d;

    refmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_async  (ref_in),
        .rise_pulse (rise)
    );

    refmon_gap_timer #(.LIMIT_CYC(LIMIT_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .expired (gap_expired)
    );

    refmon_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_LOST_HOLD),
        .done  (hold_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STARTUP;
        else        state_q <= state_d;
    end

    // Next-state logic; in PRESENT a timeout outranks a coincident edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP:   if (rise)        state_d = ST_PRESENT;
            ST_PRESENT:   if (gap_expired) state_d = ST_LOST_HOLD;
            ST_LOST_HOLD: if (hold_done)   state_d = ST_LOST_WAIT;
            ST_LOST_WAIT: if (rise)        state_d = ST_PRESENT;
            default:                       state_d = ST_STARTUP;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_lost <= 1'b1;
        else        ref_lost <= (state_d != ST_PRESENT);
    end

    // ---- checker state: length of each lost episode at the port ----
    logic          lost_q;
    logic          from_timeout_q;
    logic [LW-1:0] lost_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_q         <= 1'b1;
            from_timeout_q <= 1'b0;
            lost_len_q     <= '0;
        end else begin
            lost_q <= ref_lost;
            if (!ref_lost)                        lost_len_q <= '0;
            else if (lost_len_q != LW'(HOLD_CYC)) lost_len_q <= lost_len_q + 1'b1;
            if (!ref_lost)                        from_timeout_q <= 1'b0;
            else if (!lost_q)                     from_timeout_q <= 1'b1;
        end
    end

    // R4: a timeout episode lasts at least HOLD cycles
    p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q && !ref_lost && from_timeout_q) |-> lost_len_q >= LW'(HOLD_CYC));

    // R4: no release during the hold window
    p_hold_keeps_lost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOST_HOLD) |=> ref_lost);

    // R3: an expired gap while present raises the flag
    p_timeout_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESENT && gap_expired) |=> ref_lost);

    // R5: an edge after the hold window clears the flag
    p_edge_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOST_WAIT && rise) |=> !ref_lost);

    // R5: the flag never drops without a detected edge
    p_fall_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_lost) |-> $past(rise));

endmodule

// File: tb/refmon_loss_det_tb.sv
module refmon_loss_det_tb;
    import refmon_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_KHZ   = 800;
    localparam int FAST_KHZ   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_slow = 1'b0;
    logic ref_fast = 1'b0;
    logic lost_slow, lost_fast;

    refmon_loss_det #(.SYS_CLK_KHZ(SLOW_KHZ), .REF_CLASS(CLS_FRAME_8K)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_slow), .ref_lost(lost_slow));

    refmon_loss_det #(.SYS_CLK_KHZ(FAST_KHZ), .REF_CLASS(CLS_LINE_19M)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_fast), .ref_lost(lost_fast));

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    fast;
        bit    val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic expect_at(int at, bit fast, bit val, string tag);
        exp_t e;
        e.at = at; e.fast = fast; e.val = val; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse(bit fast, int k, int width);
        wait_cyc(k);
        if (fast) ref_fast = 1'b1; else ref_slow = 1'b1;
        repeat (width) @(negedge clk);
        if (fast) ref_fast = 1'b0; else ref_slow = 1'b0;
    endtask

    // Monitor: pops expected items in the cycle they fall due
    exp_t cur;
    logic act;
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            cur = sbq.pop_front();
            act = cur.fast ? lost_fast : lost_slow;
            n_chk++;
            if (cur.at != cyc || act !== cur.val) begin
                n_fail++;
                $display("FAIL %s cycle %0d: ref_lost actual %b expected %b",
                         cur.tag, cyc, act, cur.val);
            end
        end
    end

    initial begin
        wait_cyc(2);
        rst_n = 1'b1;

        // R1: startup state and first-edge release
        expect_at(5,  0, 1, "R1 startup");
        expect_at(25, 0, 1, "R1 no edge yet");
        expect_at(32, 0, 1, "R1 before latency");
        expect_at(33, 0, 0, "R1 first edge clears");
        pulse(0, 30, 1);                     // R7: single-cycle pulse

        // R2: nominal spacing, then spacing exactly LIMIT=125 (R8)
        expect_at(100, 0, 0, "R2 nominal");
        pulse(0, 130, 1);
        expect_at(200, 0, 0, "R2 nominal");
        pulse(0, 230, 1);
        expect_at(300, 0, 0, "R2 within tolerance");
        expect_at(357, 0, 0, "R2 gap at limit");
        pulse(0, 355, 1);
        expect_at(400, 0, 0, "R2 gap at limit");
        pulse(0, 480, 1);

        // R3: no further edge -> loss at k+LIMIT+4
        expect_at(608, 0, 0, "R3 one before timeout");
        expect_at(609, 0, 1, "R3 timeout R8");
        // R4: edges inside the hold window are ignored (WAIT from cycle 659)
        expect_at(630, 0, 1, "R4 edge in hold ignored");
        pulse(0, 620, 1);
        expect_at(660, 0, 1, "R4 edge one cycle early ignored");
        pulse(0, 656, 1);
        // R5: edge after the window releases
        expect_at(702, 0, 1, "R5 before release");
        expect_at(703, 0, 0, "R5 release");
        pulse(0, 700, 1);

        // R3: spacing LIMIT+1 with coincident edge; R4/R5 at window boundary
        expect_at(828, 0, 0, "R3 before late edge");
        expect_at(829, 0, 1, "R3 late by one cycle");
        expect_at(879, 0, 1, "R4 minimum width");
        expect_at(880, 0, 0, "R5 first allowed edge");
        pulse(0, 826, 1);
        pulse(0, 877, 1);

        // R6: 60% high phases; falling edges must not restart the gap
        expect_at(1000, 0, 0, "R6 long high phase");
        pulse(0, 977, 60);
        expect_at(1060, 0, 0, "R6 long high phase");
        expect_at(1205, 0, 0, "R6 falling edge ignored");
        expect_at(1206, 0, 1, "R6 timeout from rising edge only");
        pulse(0, 1077, 60);
        expect_at(1263, 0, 0, "R5 recover");
        pulse(0, 1260, 1);

        // R1: reset in mid-run forces the flag high until an edge
        wait_cyc(1280);
        rst_n = 1'b0;
        expect_at(1281, 0, 1, "R1 reset asserts");
        wait_cyc(1285);
        rst_n = 1'b1;
        expect_at(1300, 0, 1, "R1 after reset");

        // R8: 19.44 MHz class, LIMIT=22, HOLD=40
        expect_at(1403, 1, 0, "R8 fast first edge");
        expect_at(1420, 1, 0, "R8 fast running");
        expect_at(1463, 1, 0, "R8 fast before timeout");
        expect_at(1464, 1, 1, "R8 fast timeout");
        for (int i = 0; i < 20; i++) pulse(1, 1400 + 2*i, 1);
        expect_at(1505, 1, 1, "R4 fast hold ignores edge");
        pulse(1, 1500, 1);
        expect_at(1512, 1, 1, "R5 fast before release");
        expect_at(1513, 1, 0, "R5 fast release");
        pulse(1, 1510, 1);
        expect_at(1540, 1, 0, "R2 fast gap at limit");
        pulse(1, 1532, 1);
        expect_at(1557, 1, 0, "R3 fast before late edge");
        expect_at(1558, 1, 1, "R3 fast late by one");
        pulse(1, 1555, 1);

        wait_cyc(1600);
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items unchecked, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, cycle %0d expected < 5000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule